// File: doc/BRIEF.md
# DRAM Read/Write Mode Arbiter

This block chooses, cycle by cycle, whether the shared data bus of a memory controller serves pending reads or pending writes. It keeps an occupancy count for a read queue and for a write queue, fed by enqueue strobes and drained by its own grants. It then steers the bus between a read mode and a write mode. Writes are collected and issued in bursts. A burst starts when reads run dry and the write backlog is past a low watermark, when a drain is requested, or when the backlog reaches a high watermark. A burst ends when the backlog drops below the low watermark, when the write queue empties, or when reads are waiting and a minimum number of writes has been issued in the current phase.

Each return from writes to reads blocks read grants for a write-to-read turnaround interval. The watermarks are whole entry counts, computed as the write-queue depth times a percentage, divided by 100 and rounded down. A configuration in which the low percentage is not strictly below the high percentage stops elaboration with an error. The controller around the block treats a grant as the issue of one request from the named queue.

Top module: `rw_mode_arb`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the block is in read mode (`wr_mode` = 0) with both grants low and both levels, the phase count and the turnaround timer at zero.
- R2: Each level rises by one on an accepted enqueue and falls by one on a grant of its queue. An enqueue that arrives while the level equals its depth (32 by default) is dropped, and the matching overflow output is high in that same cycle.
- R3: At most one grant is high in any cycle, and no grant is ever given to a queue whose level is zero.
- R4: In read mode, with the turnaround timer at zero and no switch to write mode taken, `grant_rd` is high exactly when the read level is non-zero.
- R5: In read mode, with the timer at zero and the read level at zero, the block switches to write mode when the write level is non-zero and either exceeds the low watermark (16 by default) or `drain_req` is high. `wr_mode` rises in the next cycle, and no grant is given in the switching cycle.
- R6: In read mode, with the timer at zero, a write level at or above the high watermark (27 by default) forces a switch to write mode even while reads are pending.
- R7: In write mode, in every cycle that does not leave write mode, `grant_wr` is high and the phase write count rises by one, saturating at the minimum burst.
- R8: Write mode is left, with no grant in that cycle, when the write level is zero, or when it is below the low watermark with `drain_req` low, or when the read level is non-zero and the phase write count has reached the minimum burst (16 by default).
- R9: Leaving write mode clears the phase write count and loads the turnaround timer with its cycle count (4 by default). The timer counts down by one per cycle, and no read grant is given while it is non-zero.
- R10: Read mode moves to write mode only in a cycle where the turnaround timer is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_enq | input | 1 | One read request joins the read queue |
| wr_enq | input | 1 | One write request joins the write queue |
| drain_req | input | 1 | Request to empty the write queue |
| grant_rd | output | 1 | Issue one read this cycle |
| grant_wr | output | 1 | Issue one write this cycle |
| wr_mode | output | 1 | 1 while the bus is in write mode |
| rd_ovf | output | 1 | Read enqueue dropped because the read queue is full |
| wr_ovf | output | 1 | Write enqueue dropped because the write queue is full |

## Verification
A level that is off by one moves the cycle in which a watermark is crossed. It therefore shows on `wr_mode` one cycle early or late at the next switch, or as a grant to an empty queue, or as a missing overflow pulse at the full boundary. A wrong phase count shifts the end of a burst that reads are waiting behind, which shows after the sixteenth write grant. A wrong turnaround value moves the first read grant after a burst by the size of the error. Every output is compared on every cycle, so each of these faults is reported within the cycle where its effect first reaches a pin.

// File: rtl/rw_arb_pkg.sv
package rw_arb_pkg;

  typedef enum logic {
    MODE_RD = 1'b0,
    MODE_WR = 1'b1
  } arb_mode_e;

  // Whole-entry watermark: depth * percent / 100, rounded down
  function automatic int unsigned pct_of(input int unsigned depth, input int unsigned pct);
    return (depth * pct) / 100;
  endfunction

endpackage

// File: rtl/rw_occ_ctr.sv
module rw_occ_ctr #(
  parameter  int unsigned DEPTH = 32,
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq,
  input  logic          deq,
  output logic [LW-1:0] level,
  output logic          ovf
);

  logic [LW-1:0] lvl_q, lvl_d;
  logic          full, take;

  assign full  = (lvl_q == LW'(DEPTH));
  assign take  = enq && !full;
  assign ovf   = enq && full;
  assign level = lvl_q;

  always_comb begin
    lvl_d = lvl_q;
    if (take && !deq) begin
      lvl_d = lvl_q + 1'b1;
    end else if (!take && deq && (lvl_q != '0)) begin
      lvl_d = lvl_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else begin
      lvl_q <= lvl_d;
    end
  end

endmodule

// File: rtl/rw_turn_timer.sv
module rw_turn_timer #(
  parameter int unsigned CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);

  generate
    if (CYC == 0) begin : g_none
      assign busy = 1'b0;
    end else begin : g_cnt
      localparam int unsigned TW = $clog2(CYC + 1);
      logic [TW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (load) begin
          cnt_d = TW'(CYC);
        end else if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end

      assign busy = (cnt_q != '0);
    end
  endgenerate

endmodule

// File: rtl/rw_mode_ctl.sv
module rw_mode_ctl
  import rw_arb_pkg::*;
#(
  parameter  int unsigned RLW          = 6,
  parameter  int unsigned WLW          = 6,
  parameter  int unsigned HI_MARK      = 27,
  parameter  int unsigned LO_MARK      = 16,
  parameter  int unsigned MIN_WR_BURST = 16,
  localparam int unsigned PW           = $clog2(MIN_WR_BURST + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RLW-1:0] rd_lvl,
  input  logic [WLW-1:0] wr_lvl,
  input  logic           drain,
  input  logic           turn_busy,
  output logic           grant_rd,
  output logic           grant_wr,
  output logic           turn_load,
  output arb_mode_e      mode,
  output logic [PW-1:0]  phase
);

  arb_mode_e     mode_q, mode_d;
  logic [PW-1:0] phase_q, phase_d;
  logic          rd_wait, wr_any, wr_force, wr_opp, wr_done;

  assign rd_wait  = (rd_lvl != '0);
  assign wr_any   = (wr_lvl != '0);
  assign wr_force = (wr_lvl >= WLW'(HI_MARK));
  assign wr_opp   = !rd_wait && wr_any && ((wr_lvl > WLW'(LO_MARK)) || drain);
  assign wr_done  = !wr_any
                 || ((wr_lvl < WLW'(LO_MARK)) && !drain)
                 || (rd_wait && (phase_q >= PW'(MIN_WR_BURST)));

  always_comb begin
    mode_d    = mode_q;
    phase_d   = phase_q;
    grant_rd  = 1'b0;
    grant_wr  = 1'b0;
    turn_load = 1'b0;
    case (mode_q)
      MODE_RD: begin
        if (!turn_busy) begin
          if (wr_force || wr_opp) begin
            mode_d = MODE_WR;
          end else begin
            grant_rd = rd_wait;
          end
        end
      end
      MODE_WR: begin
        if (wr_done) begin
          mode_d    = MODE_RD;
          phase_d   = '0;
          turn_load = 1'b1;
        end else begin
          grant_wr = 1'b1;
          if (phase_q != PW'(MIN_WR_BURST)) begin
            phase_d = phase_q + 1'b1;
          end
        end
      end
      default: mode_d = MODE_RD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RD;
      phase_q <= '0;
    end else begin
      mode_q  <= mode_d;
      phase_q <= phase_d;
    end
  end

  assign mode  = mode_q;
  assign phase = phase_q;

endmodule

// File: rtl/rw_mode_arb.sv
module rw_mode_arb
  import rw_arb_pkg::*;
#(
  parameter int unsigned RQ_DEPTH     = 32,
  parameter int unsigned WQ_DEPTH     = 32,
  parameter int unsigned HI_PCT       = 85,
  parameter int unsigned LO_PCT       = 50,
  parameter int unsigned MIN_WR_BURST = 16,
  parameter int unsigned WTR_CYC      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_enq,
  input  logic wr_enq,
  input  logic drain_req,
  output logic grant_rd,
  output logic grant_wr,
  output logic wr_mode,
  output logic rd_ovf,
  output logic wr_ovf
);

  localparam int unsigned RLW     = $clog2(RQ_DEPTH + 1);
  localparam int unsigned WLW     = $clog2(WQ_DEPTH + 1);
  localparam int unsigned PW      = $clog2(MIN_WR_BURST + 2);
  localparam int unsigned HI_MARK = pct_of(WQ_DEPTH, HI_PCT);
  localparam int unsigned LO_MARK = pct_of(WQ_DEPTH, LO_PCT);

  generate
    if (LO_PCT >= HI_PCT) begin : g_bad_cfg
      $error("rw_mode_arb: low watermark percent must be below high watermark percent");
    end
  endgenerate

  logic [RLW-1:0] rd_lvl;
  logic [WLW-1:0] wr_lvl;
  logic [PW-1:0]  wr_phase;
  logic           turn_busy, turn_load;
  arb_mode_e      mode;

  rw_occ_ctr #(.DEPTH(RQ_DEPTH)) i_rd_occ (
    .clk   (clk),
    .rst_n (rst_n),
    .enq   (rd_enq),
    .deq   (grant_rd),
    .level (rd_lvl),
    .ovf   (rd_ovf)
  );

  rw_occ_ctr #(.DEPTH(WQ_DEPTH)) i_wr_occ (
    .clk   (clk),
    .rst_n (rst_n),
    .enq   (wr_enq),
    .deq   (grant_wr),
    .level (wr_lvl),
    .ovf   (wr_ovf)
  );

  rw_turn_timer #(.CYC(WTR_CYC)) i_turn (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (turn_load),
    .busy  (turn_busy)
  );

  rw_mode_ctl #(
    .RLW          (RLW),
    .WLW          (WLW),
    .HI_MARK      (HI_MARK),
    .LO_MARK      (LO_MARK),
    .MIN_WR_BURST (MIN_WR_BURST)
  ) i_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_lvl    (rd_lvl),
    .wr_lvl    (wr_lvl),
    .drain     (drain_req),
    .turn_busy (turn_busy),
    .grant_rd  (grant_rd),
    .grant_wr  (grant_wr),
    .turn_load (turn_load),
    .mode      (mode),
    .phase     (wr_phase)
  );

  assign wr_mode = (mode == MODE_WR);

endmodule

// File: rtl/rw_mode_arb_chk.sv
module rw_mode_arb_chk #(
  parameter int unsigned RQ_DEPTH = 32,
  parameter int unsigned WQ_DEPTH = 32,
  parameter int unsigned RLW      = 6,
  parameter int unsigned WLW      = 6,
  parameter int unsigned PW       = 5,
  parameter int unsigned HI_MARK  = 27
) (
  input logic           clk,
  input logic           rst_n,
  input logic           grant_rd,
  input logic           grant_wr,
  input logic           wr_mode,
  input logic           rd_ovf,
  input logic           wr_ovf,
  input logic [RLW-1:0] rd_lvl,
  input logic [WLW-1:0] wr_lvl,
  input logic [PW-1:0]  wr_phase,
  input logic           turn_busy
);

  p_one_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_rd && grant_wr));

  p_rd_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_rd |-> (rd_lvl != '0));

  p_wr_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_wr |-> (wr_lvl != '0));

  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lvl <= RLW'(RQ_DEPTH)) && (wr_lvl <= WLW'(WQ_DEPTH)));

  p_rd_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ovf && !grant_rd) |=> (rd_lvl == $past(rd_lvl)));

  p_wr_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ovf && !grant_wr) |=> (wr_lvl == $past(wr_lvl)));

  p_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_mode && !turn_busy && (wr_lvl >= WLW'(HI_MARK))) |=> wr_mode);

  p_grant_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_wr |-> wr_mode) and (grant_rd |-> !wr_mode));

  p_turn_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    turn_busy |-> !grant_rd);

  p_exit_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_mode) |-> (wr_phase == '0));

  p_entry_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_mode && turn_busy) |=> !wr_mode);

endmodule

bind rw_mode_arb rw_mode_arb_chk #(
  .RQ_DEPTH (RQ_DEPTH),
  .WQ_DEPTH (WQ_DEPTH),
  .RLW      (RLW),
  .WLW      (WLW),
  .PW       (PW),
  .HI_MARK  (HI_MARK)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .grant_rd  (grant_rd),
  .grant_wr  (grant_wr),
  .wr_mode   (wr_mode),
  .rd_ovf    (rd_ovf),
  .wr_ovf    (wr_ovf),
  .rd_lvl    (rd_lvl),
  .wr_lvl    (wr_lvl),
  .wr_phase  (wr_phase),
  .turn_busy (turn_busy)
);

// File: tb/test_rw_mode_arb.sv
module test_rw_mode_arb;

  localparam int CLK_PERIOD = 10;
  localparam int RQ   = 32;
  localparam int WQ   = 32;
  localparam int HI   = 27;   // 32*85/100
  localparam int LO   = 16;   // 32*50/100
  localparam int MINB = 16;
  localparam int WTR  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_enq = 1'b0, wr_enq = 1'b0, drain_req = 1'b0;
  logic grant_rd, grant_wr, wr_mode, rd_ovf, wr_ovf;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string phase_name = "reset";

  // behavioural reference state
  int m_rd = 0, m_wr = 0, m_phase = 0, m_turn = 0;
  bit m_wm = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rw_mode_arb i_rw_mode_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_enq    (rd_enq),
    .wr_enq    (wr_enq),
    .drain_req (drain_req),
    .grant_rd  (grant_rd),
    .grant_wr  (grant_wr),
    .wr_mode   (wr_mode),
    .rd_ovf    (rd_ovf),
    .wr_ovf    (wr_ovf)
  );

  function automatic void chk(input string req, input string what, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s [%s] %s: actual %0d expected %0d", req, phase_name, what, got, exp);
    end
  endfunction

  task automatic step(input bit r, input bit w, input bit d);
    bit e_gr, e_gw, e_nm, e_ld;
    @(negedge clk);
    rd_enq = r; wr_enq = w; drain_req = d;
    #1;
    e_gr = 0; e_gw = 0; e_nm = m_wm; e_ld = 0;
    if (!m_wm) begin
      if (m_turn == 0) begin
        if (m_wr >= HI || (m_rd == 0 && m_wr > 0 && (m_wr > LO || d))) e_nm = 1;
        else if (m_rd > 0) e_gr = 1;
      end
    end else if (m_wr == 0 || (m_wr < LO && !d) || (m_rd > 0 && m_phase >= MINB)) begin
      e_nm = 0; e_ld = 1;
    end else begin
      e_gw = 1;
    end
    chk("R4/R9", "grant_rd", int'(grant_rd), int'(e_gr));
    chk("R7", "grant_wr", int'(grant_wr), int'(e_gw));
    chk("R5/R6/R8/R10", "wr_mode", int'(wr_mode), int'(m_wm));
    chk("R2", "rd_ovf", int'(rd_ovf), int'(r && m_rd == RQ));
    chk("R2", "wr_ovf", int'(wr_ovf), int'(w && m_wr == WQ));
    chk("R3", "both grants", int'(grant_rd && grant_wr), 0);
    @(posedge clk);
    if (r && m_rd < RQ) m_rd++;
    if (e_gr) m_rd--;
    if (w && m_wr < WQ) m_wr++;
    if (e_gw) m_wr--;
    if (e_ld) m_phase = 0;
    else if (e_gw && m_phase < MINB) m_phase++;
    if (e_ld) m_turn = WTR;
    else if (m_turn > 0) m_turn--;
    m_wm = e_nm;
  endtask

  task automatic rand_run(input int n, input int pr, input int pw, input int pd);
    for (int i = 0; i < n; i++) begin
      step($urandom_range(99) < pr, $urandom_range(99) < pw, $urandom_range(99) < pd);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    rd_enq = 1'b1; wr_enq = 1'b1; drain_req = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1", "grant_rd in reset", int'(grant_rd), 0);
    chk("R1", "grant_wr in reset", int'(grant_wr), 0);
    chk("R1", "wr_mode in reset", int'(wr_mode), 0);
    rd_enq = 1'b0; wr_enq = 1'b0; drain_req = 1'b0;
    rst_n = 1'b1;
    phase_name = "R1 first cycle";
    step(0, 0, 0);

    phase_name = "R4 reads only";
    repeat (10) step(1, 0, 0);
    repeat (12) step(0, 0, 0);

    phase_name = "R5 low-watermark entry and exit";
    repeat (17) step(0, 1, 0);
    repeat (12) step(0, 0, 0);

    phase_name = "R5 drain entry";
    repeat (3) step(0, 1, 1);
    repeat (24) step(0, 0, 1);
    repeat (4) step(0, 0, 0);

    phase_name = "R6 forced entry, R8 min burst, R2 overflow";
    repeat (260) step(1, 1, 1);

    phase_name = "R8 empty out";
    repeat (120) step(0, 0, 0);

    phase_name = "random mixed";
    rand_run(800, 50, 50, 10);
    phase_name = "random write heavy";
    rand_run(800, 20, 80, 0);
    phase_name = "random read heavy";
    rand_run(800, 80, 30, 30);
    phase_name = "random saturating";
    rand_run(800, 90, 90, 5);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog [%s]: actual timeout expected completion", phase_name);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule